// File: doc/BRIEF.md
# GPU Power Domain Controller

This block switches a small set of GPU sub-domains (for example a geometry engine, a shared cache and pixel engines) on and off under software control. Software writes a bitmask to one of two write-only command registers, one to wake and one to put to sleep. Each selected domain then runs its own power sequence: isolation and power-enable outputs are driven in a safe order, and a power-good input from the switch fabric is awaited. A per-domain sleep status register reflects progress and can be polled.

Completion of a wake or sleep sequence is latched as a raw event. The raw events are combined with a mask register to produce a masked status and a single interrupt line. With the mask cleared, software can poll instead of taking interrupts. A programmable settle count holds isolation for extra cycles after power-good arrives. A master wake register brings every domain up with a single write. The bus is a simple 32-bit word-addressed register port whose read data follows the address in the same cycle.

Top module: `gpu_pwr_ctrl`

## Requirements
- R1: After reset every domain is powered (power enable 1, isolation 0), the sleep status (offset 0x08), mask (0x0C), raw status (0x10) and settle count (0x1C) read 0, and the interrupt is low.
- R2: A write to offset 0x04 starts a sleep sequence for exactly the domains whose bit i is 1. Status bit i reads 1 once that domain has power enable low and power-good seen low.
- R3: During a sleep sequence, isolation of a domain is asserted at least one cycle before its power enable falls.
- R4: A write to offset 0x00 wakes the selected sleeping domains. Power enable rises at once, and isolation is held until power-good is high. With settle count D (low 8 bits of 0x1C), isolation is released D edges after the first edge that samples power-good high, and status bit i returns to 0 at that moment.
- R5: Any write to offset 0x24 wakes every sleeping domain, whatever the data.
- R6: A command bit for a domain that is not in the opposite stable state has no effect, and command bits at or above the domain count are ignored.
- R7: Raw status bit 0 is set when the last domain still in a wake sequence finishes, and bit 1 is set likewise for sleep sequences. A raw bit stays set until a write to offset 0x18 has a 1 in that bit position.
- R8: Mask bits [1:0] gate the raw bits. Offset 0x14 reads raw AND mask, and the interrupt is the OR of those bits. With mask 0 the interrupt stays low while raw still records events.
- R9: Accesses that are not word aligned or that target offset 0x28 and above, as well as writes to the reserved offset 0x20, change nothing. Such reads, like reads of the write-only offsets 0x00, 0x04, 0x18 and 0x24, return 0.
- R10: The settle count register stores and reads back the low 8 bits written to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 6 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, same cycle |
| dom_pwr_en | output | 3 | Per-domain power switch enable |
| dom_iso | output | 3 | Per-domain output isolation |
| dom_pgood | input | 3 | Per-domain power-good from the switch |
| irq | output | 1 | Interrupt, OR of masked events |

## Verification
A domain sequencer stuck in a wrong state shows up at once on its power-enable and isolation pins. In the worst case it drops power while outputs are not isolated, or it frees isolation before power-good, and either shows within one cycle of the bad transition. A wrong settle count shows as isolation falling early or late by a countable number of cycles after power-good rises. A corrupted event latch shows on the next read of raw or masked status and on the interrupt line in the same cycle. A missed busy edge shows as a raw bit that never sets after the pins have settled.

// File: rtl/gpu_pwr_pkg.sv
// Shared constants and types for the GPU power domain controller.
// Assumes a 6-bit byte offset bus with word-aligned registers.
package gpu_pwr_pkg;

    localparam int ADDR_W = 6;

    // Register offsets (bytes)
    localparam logic [ADDR_W-1:0] OFS_WAKE   = 6'h00;
    localparam logic [ADDR_W-1:0] OFS_SLEEP  = 6'h04;
    localparam logic [ADDR_W-1:0] OFS_STATUS = 6'h08;
    localparam logic [ADDR_W-1:0] OFS_MASK   = 6'h0C;
    localparam logic [ADDR_W-1:0] OFS_RAW    = 6'h10;
    localparam logic [ADDR_W-1:0] OFS_MSKD   = 6'h14;
    localparam logic [ADDR_W-1:0] OFS_CLEAR  = 6'h18;
    localparam logic [ADDR_W-1:0] OFS_SETTLE = 6'h1C;
    localparam logic [ADDR_W-1:0] OFS_ALLUP  = 6'h24;
    localparam logic [ADDR_W-1:0] OFS_LIMIT  = 6'h28;

    // Event bit positions in raw/mask/masked registers
    localparam int EV_WAKE  = 0;
    localparam int EV_SLEEP = 1;
    localparam int EV_W     = 2;

    // Per-domain sequencer states
    typedef enum logic [2:0] {
        DS_ON     = 3'd0,
        DS_ISO    = 3'd1,
        DS_DRAIN  = 3'd2,
        DS_OFF    = 3'd3,
        DS_RAMP   = 3'd4,
        DS_SETTLE = 3'd5
    } dom_state_e;

endpackage

// File: rtl/pwr_domain_seq.sv
// Power sequencer for one domain.
// Sleep: isolate, drop enable, wait for power-good low.
// Wake: raise enable, wait for power-good high, hold isolation for
// the settle count, then release isolation.
// Assumes power-good stays high once it has risen during a wake.
module pwr_domain_seq
    import gpu_pwr_pkg::*;
#(
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wake_req,
    input  logic               sleep_req,
    input  logic               pgood,
    input  logic [DELAY_W-1:0] settle,
    output logic               pwr_en,
    output logic               iso,
    output logic               asleep,
    output logic               wake_busy,
    output logic               sleep_busy
);

    dom_state_e         st_q, st_d;
    logic [DELAY_W-1:0] cnt_q, cnt_d;

    // Next-state logic for the domain sequence
    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        unique case (st_q)
            DS_ON:     if (sleep_req) st_d = DS_ISO;
            DS_ISO:    st_d = DS_DRAIN;
            DS_DRAIN:  if (!pgood) st_d = DS_OFF;
            DS_OFF:    if (wake_req) st_d = DS_RAMP;
            DS_RAMP: begin
                if (pgood) begin
                    if (settle == '0) begin
                        st_d = DS_ON;
                    end else begin
                        st_d  = DS_SETTLE;
                        cnt_d = settle - 1'b1;
                    end
                end
            end
            DS_SETTLE: begin
                if (cnt_q == '0) st_d = DS_ON;
                else             cnt_d = cnt_q - 1'b1;
            end
            default:   st_d = DS_ON;
        endcase
    end

    // State and settle counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= DS_ON;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    // Pin and status decode from state
    always_comb begin
        pwr_en     = (st_q == DS_ON) || (st_q == DS_ISO) ||
                     (st_q == DS_RAMP) || (st_q == DS_SETTLE);
        iso        = (st_q != DS_ON);
        asleep     = (st_q == DS_OFF) || (st_q == DS_RAMP) || (st_q == DS_SETTLE);
        wake_busy  = (st_q == DS_RAMP) || (st_q == DS_SETTLE);
        sleep_busy = (st_q == DS_ISO) || (st_q == DS_DRAIN);
    end

    // R3
    en_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwr_en) |-> $past(iso));

    // R4
    iso_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iso) |-> ($past(pgood) && pwr_en));

    // R2
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(asleep) |-> (!pwr_en && !$past(pgood)));

    // R4
    wake_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(asleep) |-> (!iso && pwr_en));

endmodule

// File: rtl/pwr_regbank.sv
// Register decode, event latching and interrupt for the power controller.
// Read data is combinational from bus_addr. Assumes NUM_DOM < 32 and
// DELAY_W < 32. Illegal offsets are ignored on write and read as zero.
module pwr_regbank
    import gpu_pwr_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_DOM-1:0] wake_cmd,
    output logic [NUM_DOM-1:0] sleep_cmd,
    output logic [DELAY_W-1:0] settle,
    input  logic [NUM_DOM-1:0] asleep,
    input  logic               any_wake_busy,
    input  logic               any_sleep_busy,
    output logic               irq
);

    localparam int STAT_PAD = 32 - NUM_DOM;
    localparam int DLY_PAD  = 32 - DELAY_W;
    localparam int EV_PAD   = 32 - EV_W;

    logic              legal;
    logic              wr_ok;
    logic [EV_W-1:0]   mask_q;
    logic [EV_W-1:0]   raw_q;
    logic [EV_W-1:0]   ev_set;
    logic [EV_W-1:0]   ev_clr;
    logic [DELAY_W-1:0] settle_q;
    logic              wake_busy_q;
    logic              sleep_busy_q;

    // Address legality: aligned and inside the decoded window
    always_comb begin
        legal = (bus_addr[1:0] == 2'b00) && (bus_addr < OFS_LIMIT);
        wr_ok = bus_sel && bus_wr && legal;
    end

    // Command pulses to the sequencers
    always_comb begin
        wake_cmd  = '0;
        sleep_cmd = '0;
        if (wr_ok && bus_addr == OFS_WAKE)  wake_cmd  = bus_wdata[NUM_DOM-1:0];
        if (wr_ok && bus_addr == OFS_ALLUP) wake_cmd  = '1;
        if (wr_ok && bus_addr == OFS_SLEEP) sleep_cmd = bus_wdata[NUM_DOM-1:0];
    end

    // Event set on busy falling edges, clear from the clear register
    always_comb begin
        ev_set           = '0;
        ev_set[EV_WAKE]  = wake_busy_q && !any_wake_busy;
        ev_set[EV_SLEEP] = sleep_busy_q && !any_sleep_busy;
        ev_clr           = (wr_ok && bus_addr == OFS_CLEAR) ? bus_wdata[EV_W-1:0] : '0;
    end

    // Software-visible registers and busy history
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q       <= '0;
            raw_q        <= '0;
            settle_q     <= '0;
            wake_busy_q  <= 1'b0;
            sleep_busy_q <= 1'b0;
        end else begin
            wake_busy_q  <= any_wake_busy;
            sleep_busy_q <= any_sleep_busy;
            raw_q        <= (raw_q & ~ev_clr) | ev_set;
            if (wr_ok && bus_addr == OFS_MASK)   mask_q   <= bus_wdata[EV_W-1:0];
            if (wr_ok && bus_addr == OFS_SETTLE) settle_q <= bus_wdata[DELAY_W-1:0];
        end
    end

    // Read mux; write-only, reserved and illegal offsets read zero
    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr && legal) begin
            unique case (bus_addr)
                OFS_STATUS: bus_rdata = {{STAT_PAD{1'b0}}, asleep};
                OFS_MASK:   bus_rdata = {{EV_PAD{1'b0}}, mask_q};
                OFS_RAW:    bus_rdata = {{EV_PAD{1'b0}}, raw_q};
                OFS_MSKD:   bus_rdata = {{EV_PAD{1'b0}}, raw_q & mask_q};
                OFS_SETTLE: bus_rdata = {{DLY_PAD{1'b0}}, settle_q};
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign settle = settle_q;
    assign irq    = |(raw_q & mask_q);

    // R7
    wake_ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[EV_WAKE] && !ev_clr[EV_WAKE]) |=> raw_q[EV_WAKE]);

    // R7
    sleep_ev_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_q[EV_SLEEP] && !ev_clr[EV_SLEEP]) |=> raw_q[EV_SLEEP]);

    // R9
    illegal_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !legal) |=> ($stable(mask_q) && $stable(settle_q)));

    // R9
    illegal_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !legal) |-> (wake_cmd == '0 && sleep_cmd == '0));

endmodule

// File: rtl/gpu_pwr_ctrl.sv
// GPU power domain controller top: register bank plus one sequencer
// per domain. Busy flags are reduced here for completion events.
module gpu_pwr_ctrl
    import gpu_pwr_pkg::*;
#(
    parameter int NUM_DOM = 3,
    parameter int DELAY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic [5:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_DOM-1:0] dom_pwr_en,
    output logic [NUM_DOM-1:0] dom_iso,
    input  logic [NUM_DOM-1:0] dom_pgood,
    output logic               irq
);

    logic [NUM_DOM-1:0] wake_cmd;
    logic [NUM_DOM-1:0] sleep_cmd;
    logic [NUM_DOM-1:0] asleep;
    logic [NUM_DOM-1:0] wake_busy;
    logic [NUM_DOM-1:0] sleep_busy;
    logic [DELAY_W-1:0] settle;

    pwr_regbank #(.NUM_DOM(NUM_DOM), .DELAY_W(DELAY_W)) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .bus_sel        (bus_sel),
        .bus_wr         (bus_wr),
        .bus_addr       (bus_addr),
        .bus_wdata      (bus_wdata),
        .bus_rdata      (bus_rdata),
        .wake_cmd       (wake_cmd),
        .sleep_cmd      (sleep_cmd),
        .settle         (settle),
        .asleep         (asleep),
        .any_wake_busy  (|wake_busy),
        .any_sleep_busy (|sleep_busy),
        .irq            (irq)
    );

    for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
        pwr_domain_seq #(.DELAY_W(DELAY_W)) u_seq (
            .clk        (clk),
            .rst_n      (rst_n),
            .wake_req   (wake_cmd[i]),
            .sleep_req  (sleep_cmd[i]),
            .pgood      (dom_pgood[i]),
            .settle     (settle),
            .pwr_en     (dom_pwr_en[i]),
            .iso        (dom_iso[i]),
            .asleep     (asleep[i]),
            .wake_busy  (wake_busy[i]),
            .sleep_busy (sleep_busy[i])
        );
    end

endmodule

// File: tb/tb_gpu_pwr_ctrl.sv
// Scoreboard bench: driver tasks queue expected read data, a monitor
// pops and compares when the read is on the bus. Power-good is modelled
// as power enable delayed by three clocks.
module tb_gpu_pwr_ctrl;

    localparam int N = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] dom_pwr_en, dom_iso, dom_pgood;
    logic        irq;

    always #4 clk = ~clk;

    gpu_pwr_ctrl dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dom_pwr_en(dom_pwr_en), .dom_iso(dom_iso), .dom_pgood(dom_pgood),
        .irq(irq)
    );

    // power-good model
    logic [N-1:0] pg1, pg2, pg3;
    always @(posedge clk) begin
        if (!rst_n) begin
            pg1 <= '1; pg2 <= '1; pg3 <= '1;
        end else begin
            pg1 <= dom_pwr_en; pg2 <= pg1; pg3 <= pg2;
        end
    end
    assign dom_pgood = pg3;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    typedef struct {
        logic [5:0]  addr;
        logic [31:0] exp;
        string       tag;
    } rd_item_t;
    rd_item_t sb_q[$];

    task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // monitor: compare each bus read against the queue head
    always @(negedge clk) begin
        #2;
        if (bus_sel && !bus_wr) begin
            if (sb_q.size() == 0) begin
                check(0, "scoreboard empty", bus_rdata, 32'h0);
            end else begin
                rd_item_t it;
                it = sb_q.pop_front();
                check(bus_rdata == it.exp && bus_addr == it.addr, it.tag, bus_rdata, it.exp);
            end
        end
    end

    // R3 ordering monitor
    logic [N-1:0] prev_en, prev_iso;
    int ord_viol = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < N; i++)
                if (prev_en[i] && !dom_pwr_en[i] && !prev_iso[i]) ord_viol++;
        end
        prev_en  = dom_pwr_en;
        prev_iso = dom_iso;
    end

    // settle window counter for one domain
    int meas_dom = 0;
    int meas_cnt = 0;
    always @(negedge clk) begin
        if (dom_pgood[meas_dom] && dom_iso[meas_dom]) meas_cnt++;
    end

    task automatic bus_write(logic [5:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic expect_read(logic [5:0] a, logic [31:0] e, string tag);
        rd_item_t it;
        it.addr = a; it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        bus_sel = 1; bus_wr = 0; bus_addr = a;
        @(negedge clk);
        bus_sel = 0;
    endtask

    task automatic wait_pins(logic [N-1:0] en, logic [N-1:0] iso, string tag);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (dom_pwr_en == en && dom_iso == iso) break;
        end
        check(dom_pwr_en == en && dom_iso == iso, tag, {dom_pwr_en, dom_iso}, {en, iso});
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog expired", 0, 0);
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        check(dom_pwr_en == 3'b111 && dom_iso == 3'b000 && !irq, "R1 pins", {dom_pwr_en, dom_iso, irq}, 7'b1110000);
        expect_read(6'h08, 0, "R1 status");
        expect_read(6'h0C, 0, "R1 mask");
        expect_read(6'h10, 0, "R1 raw");
        expect_read(6'h1C, 0, "R1 settle");

        // R10 settle register keeps low 8 bits
        bus_write(6'h1C, 32'h1F5);
        expect_read(6'h1C, 32'hF5, "R10 settle readback");
        bus_write(6'h1C, 3);

        // R2 sleep domains 0 and 2
        bus_write(6'h04, 32'h5);
        wait_pins(3'b010, 3'b101, "R2 sleep pins");
        expect_read(6'h08, 32'h5, "R2 status");
        check(ord_viol == 0, "R3 isolation before power off", ord_viol, 0);
        // R7/R8 event with mask 0
        expect_read(6'h10, 32'h2, "R7 sleep event");
        check(!irq, "R8 irq masked", irq, 0);
        expect_read(6'h14, 0, "R8 masked zero");
        bus_write(6'h0C, 3);
        @(negedge clk);
        check(irq, "R8 irq unmasked", irq, 1);
        expect_read(6'h14, 32'h2, "R8 masked value");
        bus_write(6'h18, 0);
        expect_read(6'h10, 32'h2, "R7 clear zero keeps");
        bus_write(6'h18, 32'h2);
        expect_read(6'h10, 0, "R7 cleared");
        check(!irq, "R8 irq after clear", irq, 0);

        // R4 wake domain 0 with settle 3
        meas_dom = 0; meas_cnt = 0;
        bus_write(6'h00, 32'h1);
        wait_pins(3'b011, 3'b100, "R4 wake pins");
        check(meas_cnt == 4, "R4 settle window", meas_cnt, 4);
        expect_read(6'h08, 32'h4, "R4 status");
        expect_read(6'h10, 32'h1, "R7 wake event");
        check(irq, "R8 irq wake", irq, 1);
        bus_write(6'h18, 3);

        // R6 ignored commands
        bus_write(6'h00, 32'h2);
        bus_write(6'h04, 32'hFFFF_FFF8);
        repeat (12) @(negedge clk);
        check(dom_pwr_en == 3'b011 && dom_iso == 3'b100, "R6 no change", {dom_pwr_en, dom_iso}, 6'b011100);
        expect_read(6'h08, 32'h4, "R6 status");
        expect_read(6'h10, 0, "R6 no event");

        // R9 illegal and reserved accesses
        bus_write(6'h0D, 0);
        bus_write(6'h1D, 7);
        bus_write(6'h20, 32'hFF);
        bus_write(6'h28, 32'h1);
        bus_write(6'h3C, 32'hFF);
        expect_read(6'h0C, 32'h3, "R9 mask kept");
        expect_read(6'h1C, 32'h3, "R9 settle kept");
        expect_read(6'h20, 0, "R9 reserved reads 0");
        expect_read(6'h28, 0, "R9 out of range reads 0");
        expect_read(6'h00, 0, "R9 write-only reads 0");
        expect_read(6'h0E, 0, "R9 misaligned reads 0");
        check(dom_pwr_en == 3'b011, "R9 no command", dom_pwr_en, 3'b011);

        // R5 master wake with settle 0
        bus_write(6'h04, 32'h3);
        wait_pins(3'b000, 3'b111, "R2 all asleep");
        expect_read(6'h08, 32'h7, "R2 status all");
        bus_write(6'h18, 3);
        bus_write(6'h1C, 0);
        meas_dom = 2; meas_cnt = 0;
        bus_write(6'h24, 32'h0);
        wait_pins(3'b111, 3'b000, "R5 master wake pins");
        check(meas_cnt == 1, "R4 settle zero window", meas_cnt, 1);
        expect_read(6'h08, 0, "R5 status");
        expect_read(6'h10, 32'h1, "R7 wake event master");

        // R8 mask zero keeps irq low while raw records
        bus_write(6'h0C, 0);
        @(negedge clk);
        check(!irq, "R8 irq low mask 0", irq, 0);
        expect_read(6'h10, 32'h1, "R8 raw still set");
        expect_read(6'h14, 0, "R8 masked zero again");
        check(ord_viol == 0, "R3 final ordering", ord_viol, 0);

        repeat (3) @(negedge clk);
        check(sb_q.size() == 0, "scoreboard drained", sb_q.size(), 0);
        finish_run();
    end

endmodule